// File: doc/BRIEF.md
# Half-Word Store and Load Stage

This block is the memory-access stage of a small coprocessor attached to a slow memory built from 32-bit words and addressed in words. Each cycle it receives one decoded operation, the two register operands, the current program counter and the instruction fields. From these it builds a single memory request: a word address, a write strobe or read strobe, per-byte lane enables and the write data. The register file and the instruction decoder sit outside the block.

Stores run in one of two modes. In manual mode the word address is the address operand plus the offset field. In auto mode the address comes from an internal pointer. An offset-set operation loads the pointer, and the pointer then moves forward by itself. A store can write a whole word, made of the program counter, a 2-bit tag and the 16-bit value. It can also write one half-word, either tagged or raw. An auto-mode sequence of half-word stores fills the low half of a word first, then the high half, and only then moves to the next word.

Loads use the same register-plus-offset address and return one chosen 16-bit half of the word one cycle after the read request. The memory is expected to register its read data.

Top module: `halfword_mem_stage`

## Requirements
- R1: The op input is 3 bits wide with these codes: 0 none, 1 manual store, 2 auto store, 3 pointer set, 4 load. Manual stores and loads use the word address (addr_reg[10:0] + offset) modulo 2048, and the request appears in the same cycle as the op.
- R2: A store with wr_way 0 writes the full word {pc[10:0], 3'b000, label[1:0], val_reg[15:0]} with mem_be = 4'b1111.
- R3: A store with wr_way 1 writes the half-word {label[1:0], val_reg[13:0]} into the selected half.
- R4: A store with wr_way 3 writes val_reg[15:0] into the selected half, with no tag.
- R5: In manual mode, upper 0 selects bits 15:0 (mem_be 4'b0011) and upper 1 selects bits 31:16 (mem_be 4'b1100). The unselected half of mem_wdata is zero, and the bytes of the other half keep their contents in memory.
- R6: A store with wr_way 2 raises no mem_we, drives mem_be to 0 and does not move the auto pointer or its half state.
- R7: A pointer set (op 3) loads offset into the auto pointer and makes the next auto half-word store go to the low half. It makes no memory access.
- R8: In auto mode, half-word stores alternate between the low half and the high half of the word at the pointer, starting with the low half. The pointer advances by 1 after the high half is written. The upper input has no effect in auto mode.
- R9: An auto full-word store writes at the pointer, advances the pointer by 1 and makes the next half-word store go to the low half.
- R10: The auto pointer wraps from 2047 to 0.
- R11: A load raises mem_re in the same cycle. In the next cycle ld_valid is 1 and ld_data holds mem_rdata[15:0] if upper was 1, or mem_rdata[31:16] if upper was 0. In every other cycle ld_valid is 0.
- R12: After reset the pointer is 0 with the low half next, and mem_we, mem_re and ld_valid are 0.
- R13: Op codes 0, 5, 6 and 7 raise neither mem_we nor mem_re.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op | input | 3 | Decoded operation code |
| wr_way | input | 2 | Store layout: 0 full word, 1 tagged half, 3 raw half, 2 no write |
| upper | input | 1 | Manual store half select, or load half select |
| label | input | 2 | Tag stored with the data |
| offset | input | 11 | Word offset, or new pointer value for a pointer set |
| addr_reg | input | 16 | Address register operand |
| val_reg | input | 16 | Data register operand |
| pc | input | 11 | Program counter of the current instruction |
| mem_rdata | input | 32 | Registered read data from memory |
| mem_addr | output | 11 | Word address of the request |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_be | output | 4 | Byte lane enables for a write |
| mem_wdata | output | 32 | Write data |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 16 | Selected half-word of a load |

## Verification
Address, strobes, lane enables and write data are combinational from the op, so they are due in the same cycle. The bench drives on the falling edge and samples each table row shortly after, before the rising edge that commits the write. Pointer and half-state effects show up only in the address and lanes of the next auto store, so the table orders its rows so that each store checks the state left by the rows before it. A load result is due one rising edge after the request. The bench samples it after the following falling edge, and by then its own registered memory model has returned the word.

// File: rtl/hwsl_pkg.sv
package hwsl_pkg;
  localparam int REG_W   = 16;
  localparam int WORD_W  = 2 * REG_W;
  localparam int LBL_W   = 2;
  localparam int PC_W    = 11;
  localparam int PAD_W   = WORD_W - PC_W - LBL_W - REG_W;
  localparam int BE_W    = WORD_W / 8;
  localparam int HALF_BE = BE_W / 2;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_ST_MAN  = 3'd1,
    OP_ST_AUTO = 3'd2,
    OP_SET_PTR = 3'd3,
    OP_LOAD    = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    WAY_FULL = 2'd0,
    WAY_TAG  = 2'd1,
    WAY_RSV  = 2'd2,
    WAY_RAW  = 2'd3
  } way_e;

  // full word: program counter on top, padding, tag, value at the bottom
  function automatic logic [WORD_W-1:0] pack_full(input logic [PC_W-1:0] pcv,
                                                  input logic [LBL_W-1:0] tag,
                                                  input logic [REG_W-1:0] v);
    return {pcv, {PAD_W{1'b0}}, tag, v};
  endfunction

  // half-word: tag replaces the top bits of the value when requested
  function automatic logic [REG_W-1:0] pack_half(input logic with_tag,
                                                 input logic [LBL_W-1:0] tag,
                                                 input logic [REG_W-1:0] v);
    return with_tag ? {tag, v[REG_W-LBL_W-1:0]} : v;
  endfunction

  function automatic logic [WORD_W-1:0] place_half(input logic hi,
                                                   input logic [REG_W-1:0] h);
    return hi ? {h, {REG_W{1'b0}}} : {{REG_W{1'b0}}, h};
  endfunction

  // load select: a set flag picks the low half
  function automatic logic [REG_W-1:0] pick_half(input logic [WORD_W-1:0] w,
                                                 input logic low_sel);
    return low_sel ? w[REG_W-1:0] : w[WORD_W-1:REG_W];
  endfunction
endpackage

// File: rtl/hwsl_ptr.sv
module hwsl_ptr #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [ADDR_W-1:0] set_val,
  input  logic              adv_half,
  input  logic              adv_full,
  output logic [ADDR_W-1:0] ptr_q,
  output logic              half_q
);
  logic [ADDR_W-1:0] ptr_inc;
  assign ptr_inc = ptr_q + ADDR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      half_q <= 1'b0;
    end else if (set_en) begin
      ptr_q  <= set_val;
      half_q <= 1'b0;
    end else if (adv_full) begin
      ptr_q  <= ptr_inc;
      half_q <= 1'b0;
    end else if (adv_half) begin
      if (half_q) ptr_q <= ptr_inc;
      half_q <= ~half_q;
    end
  end
endmodule

// File: rtl/hwsl_store.sv
module hwsl_store
  import hwsl_pkg::*;
(
  input  logic              fire,
  input  logic              full,
  input  logic              hi,
  input  logic              with_tag,
  input  logic [LBL_W-1:0]  tag,
  input  logic [REG_W-1:0]  v,
  input  logic [PC_W-1:0]   pcv,
  output logic              we,
  output logic [BE_W-1:0]   be,
  output logic [WORD_W-1:0] wdata
);
  logic [WORD_W-1:0] full_word;
  logic [WORD_W-1:0] half_word;

  assign full_word = pack_full(pcv, tag, v);
  assign half_word = place_half(hi, pack_half(with_tag, tag, v));
  assign we        = fire;
  assign wdata     = !fire ? '0 : (full ? full_word : half_word);

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    localparam bit IN_HI = (g >= HALF_BE);
    assign be[g] = fire & (full | (hi == IN_HI));
  end
endmodule

// File: rtl/hwsl_load.sv
module hwsl_load
  import hwsl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              re,
  input  logic              low_sel,
  input  logic [WORD_W-1:0] rdata,
  output logic              ld_valid,
  output logic [REG_W-1:0]  ld_data
);
  logic pend_q;
  logic sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      pend_q <= re;
      if (re) sel_q <= low_sel;
    end
  end

  assign ld_valid = pend_q;
  assign ld_data  = pend_q ? pick_half(rdata, sel_q) : '0;
endmodule

// File: rtl/halfword_mem_stage.sv
module halfword_mem_stage
  import hwsl_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op,
  input  logic [1:0]        wr_way,
  input  logic              upper,
  input  logic [LBL_W-1:0]  label,
  input  logic [ADDR_W-1:0] offset,
  input  logic [REG_W-1:0]  addr_reg,
  input  logic [REG_W-1:0]  val_reg,
  input  logic [PC_W-1:0]   pc,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [BE_W-1:0]   mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              ld_valid,
  output logic [REG_W-1:0]  ld_data
);
  // decoded events, named so the checker can watch them
  logic is_man, is_auto, is_set, is_load;
  logic way_ok, way_full;
  logic st_fire, auto_half_wr, auto_full_wr;
  logic hi_sel;
  logic [ADDR_W-1:0] man_addr;
  logic [ADDR_W-1:0] ptr_q;
  logic              half_q;
  logic              unused_addr_hi;

  assign is_man   = (op == OP_ST_MAN);
  assign is_auto  = (op == OP_ST_AUTO);
  assign is_set   = (op == OP_SET_PTR);
  assign is_load  = (op == OP_LOAD);
  assign way_ok   = (wr_way != WAY_RSV);
  assign way_full = (wr_way == WAY_FULL);

  assign st_fire      = (is_man | is_auto) & way_ok;
  assign auto_half_wr = is_auto & way_ok & ~way_full;
  assign auto_full_wr = is_auto & way_full;
  assign hi_sel       = is_auto ? half_q : upper;

  assign man_addr       = addr_reg[ADDR_W-1:0] + offset;
  assign unused_addr_hi = ^addr_reg[REG_W-1:ADDR_W];
  assign mem_addr       = is_auto ? ptr_q : man_addr;
  assign mem_re         = is_load;

  hwsl_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (is_set),
    .set_val  (offset),
    .adv_half (auto_half_wr),
    .adv_full (auto_full_wr),
    .ptr_q    (ptr_q),
    .half_q   (half_q)
  );

  hwsl_store u_store (
    .fire     (st_fire),
    .full     (way_full),
    .hi       (hi_sel),
    .with_tag (wr_way == WAY_TAG),
    .tag      (label),
    .v        (val_reg),
    .pcv      (pc),
    .we       (mem_we),
    .be       (mem_be),
    .wdata    (mem_wdata)
  );

  hwsl_load u_load (
    .clk      (clk),
    .rst_n    (rst_n),
    .re       (is_load),
    .low_sel  (upper),
    .rdata    (mem_rdata),
    .ld_valid (ld_valid),
    .ld_data  (ld_data)
  );
endmodule

// File: rtl/halfword_mem_stage_chk.sv
module halfword_mem_stage_chk
  import hwsl_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        op,
  input logic [1:0]        wr_way,
  input logic [ADDR_W-1:0] offset,
  input logic              mem_we,
  input logic              mem_re,
  input logic [BE_W-1:0]   mem_be,
  input logic              ld_valid,
  input logic [ADDR_W-1:0] ptr_q,
  input logic              half_q,
  input logic              auto_half_wr
);
  AST_BE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_be == 4'b1111 || mem_be == 4'b0011 || mem_be == 4'b1100)); // R5

  AST_SET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SET_PTR) |-> (!mem_we && !mem_re)); // R7

  AST_SET_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SET_PTR) |=> (ptr_q == $past(offset) && !half_q)); // R7

  AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> ld_valid); // R11

  AST_NO_LOAD_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_re |=> !ld_valid); // R11

  AST_LOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_half_wr && !half_q) |=> (half_q && $stable(ptr_q))); // R8

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_half_wr && half_q) |=> (!half_q && ptr_q == $past(ptr_q) + ADDR_W'(1))); // R8

  AST_RSV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ST_AUTO && wr_way == WAY_RSV) |=> ($stable(ptr_q) && $stable(half_q))); // R6

  AST_RSV_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_way == WAY_RSV) |-> !mem_we); // R6
endmodule

bind halfword_mem_stage halfword_mem_stage_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op           (op),
  .wr_way       (wr_way),
  .offset       (offset),
  .mem_we       (mem_we),
  .mem_re       (mem_re),
  .mem_be       (mem_be),
  .ld_valid     (ld_valid),
  .ptr_q        (ptr_q),
  .half_q       (half_q),
  .auto_half_wr (auto_half_wr)
);

// File: tb/halfword_mem_stage_bench.sv
`timescale 1ns/1ps
module halfword_mem_stage_bench;
  localparam int AW = 11;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  way;
    logic        up;
    logic [1:0]  lbl;
    logic [10:0] off;
    logic [15:0] areg;
    logic [15:0] val;
    logic [10:0] pc;
    logic        we;
    logic [3:0]  be;
    logic [10:0] addr;
    logic [31:0] wd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{3'd2, 2'd3, 1'b0, 2'd0, 11'h000, 16'h0000, 16'hAAAA, 11'h000, 1'b1, 4'h3, 11'h000, 32'h0000AAAA, 4'd12}, // R12 reset pointer
    '{3'd1, 2'd3, 1'b0, 2'd0, 11'h005, 16'h0010, 16'hBEEF, 11'h000, 1'b1, 4'h3, 11'h015, 32'h0000BEEF, 4'd4},  // R4
    '{3'd1, 2'd3, 1'b1, 2'd0, 11'h005, 16'h0010, 16'h1234, 11'h000, 1'b1, 4'hC, 11'h015, 32'h12340000, 4'd5},  // R5
    '{3'd1, 2'd1, 1'b0, 2'd2, 11'h003, 16'h0000, 16'hFFFF, 11'h000, 1'b1, 4'h3, 11'h003, 32'h0000BFFF, 4'd3},  // R3
    '{3'd1, 2'd0, 1'b0, 2'd1, 11'h000, 16'h0020, 16'hA5A5, 11'h7FF, 1'b1, 4'hF, 11'h020, 32'hFFE1A5A5, 4'd2},  // R2
    '{3'd1, 2'd2, 1'b0, 2'd0, 11'h007, 16'h0000, 16'h1111, 11'h000, 1'b0, 4'h0, 11'h000, 32'h00000000, 4'd6},  // R6
    '{3'd1, 2'd3, 1'b0, 2'd0, 11'h002, 16'hFFFF, 16'hCAFE, 11'h000, 1'b1, 4'h3, 11'h001, 32'h0000CAFE, 4'd1},  // R1 wrap
    '{3'd3, 2'd0, 1'b0, 2'd0, 11'h040, 16'h0000, 16'h0000, 11'h000, 1'b0, 4'h0, 11'h000, 32'h00000000, 4'd7},  // R7
    '{3'd2, 2'd3, 1'b0, 2'd0, 11'h000, 16'h0000, 16'h1111, 11'h000, 1'b1, 4'h3, 11'h040, 32'h00001111, 4'd8},  // R8
    '{3'd2, 2'd1, 1'b0, 2'd3, 11'h000, 16'h0000, 16'h2222, 11'h000, 1'b1, 4'hC, 11'h040, 32'hE2220000, 4'd8},  // R8
    '{3'd2, 2'd3, 1'b0, 2'd0, 11'h000, 16'h0000, 16'h3333, 11'h000, 1'b1, 4'h3, 11'h041, 32'h00003333, 4'd8},  // R8
    '{3'd2, 2'd0, 1'b0, 2'd0, 11'h000, 16'h0000, 16'h4444, 11'h001, 1'b1, 4'hF, 11'h041, 32'h00204444, 4'd9},  // R9
    '{3'd2, 2'd3, 1'b0, 2'd0, 11'h000, 16'h0000, 16'h5555, 11'h000, 1'b1, 4'h3, 11'h042, 32'h00005555, 4'd9},  // R9
    '{3'd2, 2'd2, 1'b0, 2'd0, 11'h000, 16'h0000, 16'h0000, 11'h000, 1'b0, 4'h0, 11'h000, 32'h00000000, 4'd6},  // R6
    '{3'd2, 2'd3, 1'b1, 2'd0, 11'h000, 16'h0000, 16'h6666, 11'h000, 1'b1, 4'hC, 11'h042, 32'h66660000, 4'd6},  // R6 state kept
    '{3'd5, 2'd3, 1'b0, 2'd0, 11'h000, 16'h0000, 16'h0000, 11'h000, 1'b0, 4'h0, 11'h000, 32'h00000000, 4'd13}, // R13
    '{3'd0, 2'd3, 1'b0, 2'd0, 11'h000, 16'h0000, 16'h0000, 11'h000, 1'b0, 4'h0, 11'h000, 32'h00000000, 4'd13}, // R13
    '{3'd3, 2'd0, 1'b0, 2'd0, 11'h7FF, 16'h0000, 16'h0000, 11'h000, 1'b0, 4'h0, 11'h000, 32'h00000000, 4'd7},  // R7
    '{3'd2, 2'd3, 1'b0, 2'd0, 11'h000, 16'h0000, 16'h7777, 11'h000, 1'b1, 4'h3, 11'h7FF, 32'h00007777, 4'd10}, // R10
    '{3'd2, 2'd3, 1'b0, 2'd0, 11'h000, 16'h0000, 16'h7788, 11'h000, 1'b1, 4'hC, 11'h7FF, 32'h77880000, 4'd10}, // R10
    '{3'd2, 2'd0, 1'b0, 2'd0, 11'h000, 16'h0000, 16'h0001, 11'h000, 1'b1, 4'hF, 11'h000, 32'h00000001, 4'd10}, // R10
    '{3'd3, 2'd0, 1'b0, 2'd0, 11'h010, 16'h0000, 16'h0000, 11'h000, 1'b0, 4'h0, 11'h000, 32'h00000000, 4'd7},  // R7
    '{3'd2, 2'd3, 1'b0, 2'd0, 11'h000, 16'h0000, 16'h8888, 11'h000, 1'b1, 4'h3, 11'h010, 32'h00008888, 4'd8},  // R8
    '{3'd3, 2'd0, 1'b0, 2'd0, 11'h010, 16'h0000, 16'h0000, 11'h000, 1'b0, 4'h0, 11'h000, 32'h00000000, 4'd7},  // R7
    '{3'd2, 2'd3, 1'b0, 2'd0, 11'h000, 16'h0000, 16'h9999, 11'h000, 1'b1, 4'h3, 11'h010, 32'h00009999, 4'd7}   // R7 half cleared
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  wr_way = '0;
  logic        upper = 1'b0;
  logic [1:0]  label = '0;
  logic [10:0] offset = '0;
  logic [15:0] addr_reg = '0;
  logic [15:0] val_reg = '0;
  logic [10:0] pc = '0;
  logic [31:0] mem_rdata;
  logic [10:0] mem_addr;
  logic        mem_we, mem_re, ld_valid;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [15:0] ld_data;

  int checks = 0;
  int errors = 0;
  logic [31:0] mem [0:2047];

  always #2 clk = ~clk;

  halfword_mem_stage #(.ADDR_W(AW)) u_halfword_mem_stage (
    .clk(clk), .rst_n(rst_n), .op(op), .wr_way(wr_way), .upper(upper),
    .label(label), .offset(offset), .addr_reg(addr_reg), .val_reg(val_reg),
    .pc(pc), .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_re(mem_re), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .ld_valid(ld_valid), .ld_data(ld_data)
  );

  // bench memory with registered read data
  always_ff @(posedge clk) begin
    if (mem_we)
      for (int i = 0; i < 4; i++)
        if (mem_be[i]) mem[mem_addr][8*i +: 8] <= mem_wdata[8*i +: 8];
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] o, input logic [1:0] w, input logic u,
                       input logic [1:0] l, input logic [10:0] of,
                       input logic [15:0] ar, input logic [15:0] v, input logic [10:0] p);
    op = o; wr_way = w; upper = u; label = l; offset = of;
    addr_reg = ar; val_reg = v; pc = p;
  endtask

  task automatic do_load(input logic [15:0] ar, input logic [10:0] of,
                         input logic u, input logic [10:0] exp_addr,
                         input logic [15:0] exp_data);
    @(negedge clk);
    drive(3'd4, 2'd0, u, 2'd0, of, ar, 16'h0, 11'h0);
    #1;
    check(mem_re && !mem_we, "R11", "load strobe", {30'd0, mem_re, mem_we}, 32'h2);
    check(mem_addr == exp_addr, "R1", "load address", 32'(mem_addr), 32'(exp_addr));
    @(negedge clk);
    drive(3'd0, 2'd0, 1'b0, 2'd0, 11'h0, 16'h0, 16'h0, 11'h0);
    #1;
    check(ld_valid && ld_data == exp_data, "R11", "load data",
          {15'd0, ld_valid, ld_data}, {16'h0001, exp_data});
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    check(!mem_we && !mem_re && !ld_valid, "R12", "reset outputs",
          {29'd0, mem_we, mem_re, ld_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(VEC[k].op, VEC[k].way, VEC[k].up, VEC[k].lbl, VEC[k].off,
            VEC[k].areg, VEC[k].val, VEC[k].pc);
      #1;
      checks++;
      if (mem_we !== VEC[k].we || mem_be !== VEC[k].be || mem_re !== 1'b0 ||
          (VEC[k].we && (mem_addr !== VEC[k].addr || mem_wdata !== VEC[k].wd))) begin
        errors++;
        $display("FAIL R%0d row %0d: actual we=%b be=%h addr=%h wd=%h expected we=%b be=%h addr=%h wd=%h",
                 VEC[k].req, k, mem_we, mem_be, mem_addr, mem_wdata,
                 VEC[k].we, VEC[k].be, VEC[k].addr, VEC[k].wd);
      end
    end
    @(negedge clk);
    drive(3'd0, 2'd0, 1'b0, 2'd0, 11'h0, 16'h0, 16'h0, 11'h0);
    #1;
    check(!ld_valid, "R11", "no valid without load", {31'd0, ld_valid}, 32'h0);

    // half-word writes kept the other half (R5), loads pick halves (R11)
    do_load(16'h0010, 11'h005, 1'b1, 11'h015, 16'hBEEF);
    do_load(16'h0010, 11'h005, 1'b0, 11'h015, 16'h1234);
    do_load(16'h0040, 11'h000, 1'b0, 11'h040, 16'hE222);
    do_load(16'h0040, 11'h000, 1'b1, 11'h040, 16'h1111);
    do_load(16'h0000, 11'h020, 1'b0, 11'h020, 16'hFFE1);
    do_load(16'h0000, 11'h041, 1'b1, 11'h041, 16'h4444);  // R9 full word at 0x041

    // reset in the middle of a half pair brings the pointer back (R12)
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(3'd2, 2'd3, 1'b0, 2'd0, 11'h0, 16'h0, 16'h0BAD, 11'h0);
    #1;
    check(mem_addr == 11'h000 && mem_be == 4'h3, "R12", "store after reset",
          {mem_be, 17'd0, mem_addr}, {4'h3, 28'h0});
    @(negedge clk);
    drive(3'd0, 2'd0, 1'b0, 2'd0, 11'h0, 16'h0, 16'h0, 11'h0);
    repeat (2) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule